// File: doc/BRIEF.md
# Serial Clock-Enable Control Slave

This block is the control side of a clock generator. An external controller writes it over a two-wire serial bus. It holds a small bank of 8-bit control registers: per-output clock enable bits, plus a spread-spectrum select in the last register. The bus is write-only, and nothing can be read back. After reset every register bit is 1, so all outputs run and the chip works with no serial access at all.

Both bus lines are sampled with the system clock. The block finds start and stop conditions and checks three header bytes in order: the bus address with the write bit, a fixed command code, and a byte count. Data bytes after the header load registers 0, 1, 2 in that order. The slave pulls SDA low in the acknowledge slot of every byte it accepts. A register takes its new byte only once that byte and its acknowledge slot are complete.

Top module: `clk_ctl_i2c_slave`

## Requirements
- R1: Reset sets every bit of `ctrl_o` to 1 (register i sits at bits 8i+7..8i) and releases `sda_oe_o`.
- R2: The first byte after a start is acknowledged only when it equals 0xD2. Any other value is not acknowledged, and no later byte of that transfer is acknowledged or stored.
- R3: A read request (address byte 0xD3, low bit set) is never acknowledged, and it changes no register.
- R4: The second byte must be 0x00. Any other value is not acknowledged, and the rest of the transfer is ignored.
- R5: The third byte (the count) is always acknowledged. The data bytes that follow load register 0, then 1, then 2, and are shifted in most significant bit first.
- R6: Data bytes beyond register 2 that are still within the count are acknowledged and discarded.
- R7: Data bytes beyond the count are not acknowledged and not stored. A count of 0 stores nothing.
- R8: A register changes only after its whole byte and its acknowledge slot have completed. A stop or start in the middle of a byte leaves that register unchanged.
- R9: `sda_oe_o` is asserted only in the acknowledge slot: it rises after the falling SCL edge that ends the eighth bit and falls after the next falling SCL edge.
- R10: SCL passes through a 2-flop synchronizer, and a level change is accepted only after the synchronized level has differed for 2 consecutive system clocks. A 1-clock SCL pulse shifts no bit.
- R11: A repeated start in the middle of a transfer restarts the address phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe_o | output | 1 | 1 pulls SDA low (acknowledge) |
| ctrl_o | output | 24 | Control registers, register i at bits 8i+7..8i |

## Verification
The bound checker checks four things on every cycle. The registers move only on a commit that follows an asserted acknowledge. The acknowledge drive rises and falls only while the filtered SCL is low. The filtered SCL never changes before the synchronized level has held for two clocks. The bench scenarios cover the rest: header matching, read rejection, fill order, discard past register 2, the count limit, aborts in the middle of a byte, repeated start, and glitch rejection, because each of these depends on a whole byte sequence.

// File: rtl/clk_ctl_pkg.sv
package clk_ctl_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_CMD,
    ST_CNT,
    ST_DATA,
    ST_SKIP
  } xfer_st_e;
endpackage

// File: rtl/ctl_line_sync.sv
module ctl_line_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned HOLD   = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s_o,
  output logic scl_f_o,
  output logic sda_s_o
);
  localparam int unsigned CNT_W = $clog2(HOLD + 1);

  logic [STAGES-1:0] scl_ff, sda_ff;
  logic [CNT_W-1:0]  cnt_q;
  logic              scl_f_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= '1;
      sda_ff <= '1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
    end
  end

  assign scl_s_o = scl_ff[STAGES-1];
  assign sda_s_o = sda_ff[STAGES-1];

  // accept a new SCL level only after HOLD consecutive differing samples
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_f_q <= 1'b1;
      cnt_q   <= '0;
    end else if (scl_s_o == scl_f_q) begin
      cnt_q <= '0;
    end else if (cnt_q == CNT_W'(HOLD - 1)) begin
      scl_f_q <= scl_s_o;
      cnt_q   <= '0;
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign scl_f_o = scl_f_q;
endmodule

// File: rtl/ctl_bus_events.sv
module ctl_bus_events (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_f_i,
  input  logic sda_s_i,
  output logic start_o,
  output logic stop_o,
  output logic scl_rise_o,
  output logic scl_fall_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f_i;
      sda_q <= sda_s_i;
    end
  end

  assign start_o    = scl_f_i & scl_q & sda_q & ~sda_s_i;
  assign stop_o     = scl_f_i & scl_q & ~sda_q & sda_s_i;
  assign scl_rise_o = scl_f_i & ~scl_q;
  assign scl_fall_o = ~scl_f_i & scl_q;
endmodule

// File: rtl/ctl_xfer_fsm.sv
module ctl_xfer_fsm
  import clk_ctl_pkg::*;
#(
  parameter int unsigned NREG     = 3,
  parameter logic [6:0]  SLV_ADDR = 7'h69,
  parameter logic [7:0]  CMD_CODE = 8'h00,
  localparam int unsigned IDX_W   = $clog2(NREG + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              sda_s_i,
  output logic              sda_oe_o,
  output logic              wr_en_o,
  output logic [IDX_W-1:0]  wr_idx_o,
  output logic [BYTE_W-1:0] wr_data_o
);
  xfer_st_e          st_q;
  logic [3:0]        bit_cnt_q;
  logic [BYTE_W-1:0] shreg_q;
  logic [BYTE_W-1:0] remain_q;
  logic [IDX_W-1:0]  idx_q;
  logic              in_ack_q, ack_q, oe_q;
  logic              ack_now;

  always_comb begin
    case (st_q)
      ST_ADDR: ack_now = (shreg_q == {SLV_ADDR, 1'b0});
      ST_CMD:  ack_now = (shreg_q == CMD_CODE);
      ST_CNT:  ack_now = 1'b1;
      ST_DATA: ack_now = (remain_q != '0);
      default: ack_now = 1'b0;
    endcase
  end

  // commit at the falling SCL edge that closes an acknowledged data slot
  assign wr_en_o   = scl_fall_i & in_ack_q & ack_q & (st_q == ST_DATA)
                   & (idx_q < IDX_W'(NREG));
  assign wr_idx_o  = idx_q;
  assign wr_data_o = shreg_q;
  assign sda_oe_o  = oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      bit_cnt_q <= '0;
      shreg_q   <= '0;
      remain_q  <= '0;
      idx_q     <= '0;
      in_ack_q  <= 1'b0;
      ack_q     <= 1'b0;
      oe_q      <= 1'b0;
    end else if (start_i || stop_i) begin
      st_q      <= start_i ? ST_ADDR : ST_IDLE;
      bit_cnt_q <= '0;
      in_ack_q  <= 1'b0;
      ack_q     <= 1'b0;
      oe_q      <= 1'b0;
    end else if (st_q == ST_IDLE || st_q == ST_SKIP) begin
      oe_q <= 1'b0;
    end else if (scl_rise_i && !in_ack_q && bit_cnt_q < 4'd8) begin
      shreg_q   <= {shreg_q[BYTE_W-2:0], sda_s_i};
      bit_cnt_q <= bit_cnt_q + 4'd1;
    end else if (scl_fall_i && !in_ack_q && bit_cnt_q == 4'd8) begin
      in_ack_q <= 1'b1;
      ack_q    <= ack_now;
      oe_q     <= ack_now;
    end else if (scl_fall_i && in_ack_q) begin
      in_ack_q  <= 1'b0;
      oe_q      <= 1'b0;
      bit_cnt_q <= '0;
      if (!ack_q) begin
        st_q <= ST_SKIP;
      end else begin
        case (st_q)
          ST_ADDR: st_q <= ST_CMD;
          ST_CMD:  st_q <= ST_CNT;
          ST_CNT: begin
            remain_q <= shreg_q;
            idx_q    <= '0;
            st_q     <= ST_DATA;
          end
          ST_DATA: begin
            remain_q <= remain_q - BYTE_W'(1);
            if (idx_q < IDX_W'(NREG)) idx_q <= idx_q + IDX_W'(1);
          end
          default: st_q <= ST_SKIP;
        endcase
      end
    end
  end
endmodule

// File: rtl/ctl_reg_bank.sv
module ctl_reg_bank
  import clk_ctl_pkg::*;
#(
  parameter int unsigned                NREG    = 3,
  parameter logic [NREG*BYTE_W-1:0]     DEFAULT = '1,
  localparam int unsigned               IDX_W   = $clog2(NREG + 1)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_en_i,
  input  logic [IDX_W-1:0]         wr_idx_i,
  input  logic [BYTE_W-1:0]        wr_data_i,
  output logic [NREG*BYTE_W-1:0]   regs_o
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        regs_o[g*BYTE_W +: BYTE_W] <= DEFAULT[g*BYTE_W +: BYTE_W];
      end else if (wr_en_i && wr_idx_i == IDX_W'(g)) begin
        regs_o[g*BYTE_W +: BYTE_W] <= wr_data_i;
      end
    end
  end
endmodule

// File: rtl/clk_ctl_i2c_slave.sv
module clk_ctl_i2c_slave
  import clk_ctl_pkg::*;
#(
  parameter int unsigned            NREG        = 3,
  parameter logic [6:0]             SLV_ADDR    = 7'h69,
  parameter logic [7:0]             CMD_CODE    = 8'h00,
  parameter int unsigned            SYNC_STAGES = 2,
  parameter int unsigned            SCL_HOLD    = 2,
  parameter logic [NREG*BYTE_W-1:0] DEFAULT     = '1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   scl_i,
  input  logic                   sda_i,
  output logic                   sda_oe_o,
  output logic [NREG*BYTE_W-1:0] ctrl_o
);
  localparam int unsigned IDX_W = $clog2(NREG + 1);

  logic              scl_s, scl_f, sda_s;
  logic              start, stop, scl_rise, scl_fall;
  logic              wr_en;
  logic [IDX_W-1:0]  wr_idx;
  logic [BYTE_W-1:0] wr_data;

  ctl_line_sync #(.STAGES(SYNC_STAGES), .HOLD(SCL_HOLD)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_s_o(scl_s), .scl_f_o(scl_f), .sda_s_o(sda_s)
  );

  ctl_bus_events u_events (
    .clk_i, .rst_ni, .scl_f_i(scl_f), .sda_s_i(sda_s),
    .start_o(start), .stop_o(stop), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall)
  );

  ctl_xfer_fsm #(.NREG(NREG), .SLV_ADDR(SLV_ADDR), .CMD_CODE(CMD_CODE)) u_fsm (
    .clk_i, .rst_ni, .start_i(start), .stop_i(stop),
    .scl_rise_i(scl_rise), .scl_fall_i(scl_fall), .sda_s_i(sda_s),
    .sda_oe_o, .wr_en_o(wr_en), .wr_idx_o(wr_idx), .wr_data_o(wr_data)
  );

  ctl_reg_bank #(.NREG(NREG), .DEFAULT(DEFAULT)) u_regs (
    .clk_i, .rst_ni, .wr_en_i(wr_en), .wr_idx_i(wr_idx),
    .wr_data_i(wr_data), .regs_o(ctrl_o)
  );
endmodule

// File: rtl/clk_ctl_sva.sv
module clk_ctl_sva #(
  parameter int unsigned W = 24
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         scl_s,
  input logic         scl_f,
  input logic         sda_oe_o,
  input logic         wr_en,
  input logic [W-1:0] ctrl_o
);
  // register bank moves only on a commit that follows a driven acknowledge
  assert_reg_on_commit_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ctrl_o) |-> $past(wr_en));

  assert_commit_after_ack_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |-> sda_oe_o);

  assert_ack_rise_scl_low_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> !scl_f);

  assert_ack_fall_scl_low_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sda_oe_o) |-> !scl_f);

  assert_scl_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(scl_f) |-> ($past(scl_s, 1) == scl_f && $past(scl_s, 2) == scl_f));
endmodule

bind clk_ctl_i2c_slave clk_ctl_sva #(.W(NREG * clk_ctl_pkg::BYTE_W)) u_sva (
  .clk_i(clk_i), .rst_ni(rst_ni), .scl_s(scl_s), .scl_f(scl_f),
  .sda_oe_o(sda_oe_o), .wr_en(wr_en), .ctrl_o(ctrl_o)
);

// File: tb/clk_ctl_i2c_slave_bench.sv
module clk_ctl_i2c_slave_bench;
  localparam int Q = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scl = 1'b1;
  logic        sda_drv = 1'b1;
  logic        sda_line;
  logic        sda_oe;
  logic [23:0] ctrl;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  assign sda_line = sda_drv & ~sda_oe;

  clk_ctl_i2c_slave u_clk_ctl_i2c_slave (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .ctrl_o(ctrl)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_drv = 1'b1; wq(Q);
    scl = 1'b1;     wq(Q);
    sda_drv = 1'b0; wq(Q);
    scl = 1'b0;     wq(Q);
  endtask

  task automatic bus_stop();
    sda_drv = 1'b0; wq(Q);
    scl = 1'b1;     wq(Q);
    sda_drv = 1'b1; wq(Q);
  endtask

  task automatic send_bit(input logic b, input bit glitch);
    sda_drv = b;
    if (glitch) begin
      wq(Q / 2);
      scl = 1'b1; wq(1);
      scl = 1'b0; wq(Q / 2 - 1);
    end else begin
      wq(Q);
    end
    scl = 1'b1; wq(2 * Q);
    scl = 1'b0; wq(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit glitch, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i], glitch && i == 5);
    sda_drv = 1'b1; wq(Q);
    scl = 1'b1;     wq(Q);
    ack = sda_oe;   wq(Q);
    scl = 1'b0;     wq(Q);
  endtask

  task automatic xfer(input logic [7:0] b[8], input int n, input bit glitch, output logic [7:0] acks);
    logic a;
    acks = '0;
    bus_start();
    for (int i = 0; i < n; i++) begin
      send_byte(b[i], glitch && i >= 3, a);
      acks[i] = a;
    end
    bus_stop();
    wq(4);
  endtask

  task automatic t_reset();
    chk(ctrl == 24'hFFFFFF, "R1 reset ctrl", 32'(ctrl), 32'hFFFFFF);
    chk(sda_oe == 1'b0, "R1 reset sda_oe", 32'(sda_oe), 0);
  endtask

  task automatic t_full();
    logic [7:0] acks;
    xfer('{8'hD2, 8'h00, 8'h03, 8'hA1, 8'hB2, 8'hC3, 8'h0, 8'h0}, 6, 1'b0, acks);
    chk(acks[5:0] == 6'h3F, "R2 R5 R9 acks full write", 32'(acks), 32'h3F);
    chk(ctrl == 24'hC3B2A1, "R5 fill order", 32'(ctrl), 32'hC3B2A1);
    chk(sda_oe == 1'b0, "R9 released after transfer", 32'(sda_oe), 0);
  endtask

  task automatic t_bad_addr();
    logic [7:0] acks;
    xfer('{8'hA4, 8'h00, 8'h03, 8'h11, 8'h22, 8'h33, 8'h0, 8'h0}, 6, 1'b0, acks);
    chk(acks == 8'h00, "R2 foreign address acks", 32'(acks), 0);
    chk(ctrl == 24'hC3B2A1, "R2 foreign address no write", 32'(ctrl), 32'hC3B2A1);
  endtask

  task automatic t_read();
    logic [7:0] acks;
    xfer('{8'hD3, 8'h00, 8'h03, 8'h44, 8'h0, 8'h0, 8'h0, 8'h0}, 4, 1'b0, acks);
    chk(acks == 8'h00, "R3 read request acks", 32'(acks), 0);
    chk(ctrl == 24'hC3B2A1, "R3 read no write", 32'(ctrl), 32'hC3B2A1);
  endtask

  task automatic t_bad_cmd();
    logic [7:0] acks;
    xfer('{8'hD2, 8'h05, 8'h03, 8'h11, 8'h0, 8'h0, 8'h0, 8'h0}, 4, 1'b0, acks);
    chk(acks == 8'h01, "R4 bad command acks", 32'(acks), 1);
    chk(ctrl == 24'hC3B2A1, "R4 bad command no write", 32'(ctrl), 32'hC3B2A1);
  endtask

  task automatic t_count();
    logic [7:0] acks;
    xfer('{8'hD2, 8'h00, 8'h01, 8'h5A, 8'h6B, 8'h0, 8'h0, 8'h0}, 5, 1'b0, acks);
    chk(acks == 8'h0F, "R7 count limit acks", 32'(acks), 32'h0F);
    chk(ctrl == 24'hC3B25A, "R7 count limit regs", 32'(ctrl), 32'hC3B25A);
    xfer('{8'hD2, 8'h00, 8'h00, 8'h77, 8'h0, 8'h0, 8'h0, 8'h0}, 4, 1'b0, acks);
    chk(acks == 8'h07, "R7 zero count acks", 32'(acks), 32'h07);
    chk(ctrl == 24'hC3B25A, "R7 zero count regs", 32'(ctrl), 32'hC3B25A);
  endtask

  task automatic t_overflow();
    logic [7:0] acks;
    xfer('{8'hD2, 8'h00, 8'h05, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05}, 8, 1'b0, acks);
    chk(acks == 8'hFF, "R6 overflow acks", 32'(acks), 32'hFF);
    chk(ctrl == 24'h030201, "R6 overflow regs", 32'(ctrl), 32'h030201);
  endtask

  task automatic t_stop_mid();
    logic a;
    bus_start();
    send_byte(8'hD2, 1'b0, a);
    send_byte(8'h00, 1'b0, a);
    send_byte(8'h03, 1'b0, a);
    send_byte(8'h77, 1'b0, a);
    chk(a == 1'b1, "R8 first data ack", 32'(a), 1);
    for (int i = 0; i < 4; i++) send_bit(1'b1, 1'b0);
    bus_stop();
    wq(4);
    chk(ctrl == 24'h030277, "R8 stop mid byte", 32'(ctrl), 32'h030277);
  endtask

  task automatic t_rstart();
    logic a;
    bus_start();
    send_byte(8'hD2, 1'b0, a);
    send_byte(8'h00, 1'b0, a);
    send_byte(8'h02, 1'b0, a);
    for (int i = 0; i < 3; i++) send_bit(1'b1, 1'b0);
    bus_start();
    send_byte(8'hD2, 1'b0, a);
    chk(a == 1'b1, "R11 address after repeated start", 32'(a), 1);
    send_byte(8'h00, 1'b0, a);
    send_byte(8'h01, 1'b0, a);
    send_byte(8'hEE, 1'b0, a);
    bus_stop();
    wq(4);
    chk(ctrl == 24'h0302EE, "R11 R8 repeated start regs", 32'(ctrl), 32'h0302EE);
  endtask

  task automatic t_glitch();
    logic [7:0] acks;
    xfer('{8'hD2, 8'h00, 8'h02, 8'h3C, 8'h4D, 8'h0, 8'h0, 8'h0}, 5, 1'b1, acks);
    chk(acks == 8'h1F, "R10 glitch acks", 32'(acks), 32'h1F);
    chk(ctrl == 24'h034D3C, "R10 glitch regs", 32'(ctrl), 32'h034D3C);
  endtask

  initial begin
    wq(5);
    rst_n = 1'b1;
    wq(5);
    t_reset();
    t_full();
    t_bad_addr();
    t_read();
    t_bad_cmd();
    t_count();
    t_overflow();
    t_stop_mid();
    t_rstart();
    t_glitch();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule